// File: doc/BRIEF.md
# Multichannel SPI Register Bank

This block is the software-visible register file of a multichannel SPI master. A 32-bit bus with separate read and write strobes and a word address reaches a set of global registers and four identical per-channel banks. The bank stores each channel's configuration and enable and presents them to a transfer engine. It hands transmit words to that engine and captures received words from it. It keeps per-channel status flags and derives DMA request lines from those flags.

The global registers hold a fixed revision code, system configuration (auto-idle and a self-clearing soft reset), a reset-done status bit, interrupt status and enable words, a wakeup enable bit, a system test word and module control (single-channel, slave/master, test mode). The block leaves reset in slave mode, so software must clear the slave bit before master operation. Chip-select forcing is a configuration bit of its own and does not depend on the channel enable. A soft reset returns every register to its default and holds the bank in a short quiet period before reset-done reads 1.

Top module: `mspi_regfile`

## Requirements
- R1: After reset, revision reads the REVISION parameter (default 0x0000_0021), module control reads 0x4 (slave bit 2 set), every channel status reads 0x6 (transmit-empty bit 1 and end-of-transfer bit 2 set), configuration, control, TX and RX read 0, and mod_slave is 1.
- R2: bus_addr is a word address. The global words are revision 0, system config 4, system status 5, IRQ status 6, IRQ enable 7, wakeup 8, system test 9 and module control 10. Channel n starts at word 11+5n and holds config, status, control, TX and RX at +0 to +4. Read data appears on bus_rdata one cycle after the read strobe.
- R3: While reset-done (system status bit 0) is 0, every register is held at its default and bus writes are ignored. After hardware reset, and after a write of system config with bit 1 set, reset-done reads 0 for SRST_CYCLES (default 4) read cycles and then reads 1. Bit 1 of system config always reads 0.
- R4: A rx_push pulse stores the channel's rx_word slice and sets status bit 0. Reading the channel's RX word returns the stored word and clears bit 0 unless a push arrives in the same cycle.
- R5: Writing a channel's TX word stores it on tx_word and pulses that channel's tx_load bit for exactly one cycle. The pulse is visible in the cycle after the write. The write clears status bits 1 and 2. eng_tx_empty sets bit 1 and eng_eot sets bit 2.
- R6: dma_wr_req is set while config bit 14 and status bit 1 are both set. dma_rd_req is set while config bit 15 and status bit 0 are both set.
- R7: Channel config bits 20:0 are read/write and bits 31:21 read 0. The 21 bits appear on ch_cfg, with bit 20 forcing chip select. Control bit 0 is the channel enable on ch_enable.
- R8: Module control stores bit 0 (single channel), bit 2 (slave) and bit 3 (test) and drives mod_single, mod_slave and mod_systest from them. Its other bits read 0.
- R9: Writes to revision, system status, channel status and RX words have no effect. Unmapped words read 0 and ignore writes.
- R10: System config bit 0 and wakeup bit 0 are read/write. IRQ status, IRQ enable and system test are full 32-bit read/write words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| mod_single | output | 1 | Single-channel mode |
| mod_slave | output | 1 | Slave mode when 1 |
| mod_systest | output | 1 | System test mode |
| ch_cfg | output | 84 | Per-channel 21-bit configuration, channel n at [21n +: 21] |
| ch_enable | output | 4 | Per-channel enable |
| tx_load | output | 4 | One-cycle pulse: new transmit word |
| tx_word | output | 128 | Per-channel transmit word, channel n at [32n +: 32] |
| rx_push | input | 4 | Engine delivers a received word |
| rx_word | input | 128 | Per-channel received word |
| eng_tx_empty | input | 4 | Engine took the transmit word |
| eng_eot | input | 4 | Engine finished shifting |
| dma_wr_req | output | 4 | DMA write request |
| dma_rd_req | output | 4 | DMA read request |

## Verification
On every cycle the assertions check four properties: the quiet state of all channel outputs while reset-done is low, the single-cycle transmit load after a TX write, the fall of the write request after that write, and the rise and fall of the read request around a push and an RX read. Only the bench's scenarios can show the exact length of the reset-done window, that read-only and unmapped words are ignored, the read-back masks of every register and the stored word values. The bench also runs a random mix of engine events and bus accesses against a model of the status flags and DMA requests.

// File: rtl/mspi_regfile.sv
module mspi_regfile #(
  parameter int NCH = 4,
  parameter int AW = 6,
  parameter int SRST_CYCLES = 4,
  parameter logic [31:0] REVISION = 32'h0000_0021
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mod_single,
  output logic              mod_slave,
  output logic              mod_systest,
  output logic [NCH*21-1:0] ch_cfg,
  output logic [NCH-1:0]    ch_enable,
  output logic [NCH-1:0]    tx_load,
  output logic [NCH*32-1:0] tx_word,
  input  logic [NCH-1:0]    rx_push,
  input  logic [NCH*32-1:0] rx_word,
  input  logic [NCH-1:0]    eng_tx_empty,
  input  logic [NCH-1:0]    eng_eot,
  output logic [NCH-1:0]    dma_wr_req,
  output logic [NCH-1:0]    dma_rd_req
);
  localparam int CFGW = 21;
  localparam int BANK = 5;
  localparam int CH0 = 11;
  localparam int CNTW = $clog2(SRST_CYCLES + 1);
  localparam logic [AW-1:0] A_REV = AW'(0), A_SCFG = AW'(4), A_SSTAT = AW'(5),
    A_IRQS = AW'(6), A_IRQE = AW'(7), A_WAKE = AW'(8), A_TEST = AW'(9), A_MODC = AW'(10);

  logic [CNTW-1:0] rcnt;
  logic done, wr, sreq, clr;
  logic autoidle, wake;
  logic [31:0] irq_st, irq_en, systest;
  logic [2:0] modc;
  logic [NCH-1:0][31:0] ch_rv;
  logic [31:0] rv;

  assign done = (rcnt == '0);
  assign wr   = bus_wr & done;
  assign sreq = wr && (bus_addr == A_SCFG) && bus_wdata[1];
  assign clr  = sreq | ~done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rcnt <= CNTW'(SRST_CYCLES);
    else if (sreq)  rcnt <= CNTW'(SRST_CYCLES);
    else if (!done) rcnt <= rcnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      autoidle <= 1'b0; wake <= 1'b0; irq_st <= '0; irq_en <= '0;
      systest <= '0; modc <= 3'b010;
    end else if (clr) begin
      autoidle <= 1'b0; wake <= 1'b0; irq_st <= '0; irq_en <= '0;
      systest <= '0; modc <= 3'b010;
    end else if (wr) begin
      case (bus_addr)
        A_SCFG: autoidle <= bus_wdata[0];
        A_IRQS: irq_st   <= bus_wdata;
        A_IRQE: irq_en   <= bus_wdata;
        A_WAKE: wake     <= bus_wdata[0];
        A_TEST: systest  <= bus_wdata;
        A_MODC: modc     <= {bus_wdata[3], bus_wdata[2], bus_wdata[0]};
        default: ;
      endcase
    end

  assign mod_single  = modc[0];
  assign mod_slave   = modc[1];
  assign mod_systest = modc[2];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [AW-1:0] B_CFG  = AW'(CH0 + BANK*g);
    localparam logic [AW-1:0] B_STAT = AW'(CH0 + BANK*g + 1);
    localparam logic [AW-1:0] B_CTL  = AW'(CH0 + BANK*g + 2);
    localparam logic [AW-1:0] B_TX   = AW'(CH0 + BANK*g + 3);
    localparam logic [AW-1:0] B_RX   = AW'(CH0 + BANK*g + 4);
    logic [CFGW-1:0] cfg_q;
    logic [31:0] tx_q, rx_q;
    logic en_q, tld_q, rxs_q, txs_q, eot_q;
    logic w_tx;

    assign w_tx = wr && (bus_addr == B_TX);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cfg_q <= '0; en_q <= 1'b0; tx_q <= '0; rx_q <= '0; tld_q <= 1'b0;
        rxs_q <= 1'b0; txs_q <= 1'b1; eot_q <= 1'b1;
      end else if (clr) begin
        cfg_q <= '0; en_q <= 1'b0; tx_q <= '0; rx_q <= '0; tld_q <= 1'b0;
        rxs_q <= 1'b0; txs_q <= 1'b1; eot_q <= 1'b1;
      end else begin
        if (wr && bus_addr == B_CFG) cfg_q <= bus_wdata[CFGW-1:0];
        if (wr && bus_addr == B_CTL) en_q <= bus_wdata[0];
        tld_q <= w_tx;
        if (w_tx) begin
          tx_q <= bus_wdata; txs_q <= 1'b0; eot_q <= 1'b0;
        end else begin
          if (eng_tx_empty[g]) txs_q <= 1'b1;
          if (eng_eot[g])      eot_q <= 1'b1;
        end
        if (rx_push[g]) begin
          rx_q <= rx_word[g*32 +: 32]; rxs_q <= 1'b1;
        end else if (bus_rd && bus_addr == B_RX) begin
          rxs_q <= 1'b0;
        end
      end

    assign ch_rv[g] = (bus_addr == B_CFG)  ? {{(32-CFGW){1'b0}}, cfg_q} :
                      (bus_addr == B_STAT) ? {29'b0, eot_q, txs_q, rxs_q} :
                      (bus_addr == B_CTL)  ? {31'b0, en_q} :
                      (bus_addr == B_TX)   ? tx_q :
                      (bus_addr == B_RX)   ? rx_q : 32'b0;

    assign ch_cfg[g*CFGW +: CFGW] = cfg_q;
    assign ch_enable[g]  = en_q;
    assign tx_load[g]    = tld_q;
    assign tx_word[g*32 +: 32] = tx_q;
    assign dma_wr_req[g] = cfg_q[14] & txs_q;
    assign dma_rd_req[g] = cfg_q[15] & rxs_q;
  end

  always_comb begin
    rv = '0;
    case (bus_addr)
      A_REV:   rv = REVISION;
      A_SCFG:  rv = {31'b0, autoidle};
      A_SSTAT: rv = {31'b0, done};
      A_IRQS:  rv = irq_st;
      A_IRQE:  rv = irq_en;
      A_WAKE:  rv = {31'b0, wake};
      A_TEST:  rv = systest;
      A_MODC:  rv = {28'b0, modc[2], modc[1], 1'b0, modc[0]};
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) rv = rv | ch_rv[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rv;

endmodule

module mspi_regfile_chk #(
  parameter int NCH = 4,
  parameter int AW = 6
)(
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              done,
  input logic [NCH-1:0]    rx_push,
  input logic [NCH-1:0]    tx_load,
  input logic [NCH*21-1:0] ch_cfg,
  input logic [NCH-1:0]    ch_enable,
  input logic [NCH-1:0]    dma_wr_req,
  input logic [NCH-1:0]    dma_rd_req
);
  a_r3_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (ch_cfg == '0 && ch_enable == '0 && dma_wr_req == '0 && dma_rd_req == '0 && tx_load == '0));

  a_r5_single_load: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tx_load));

  for (genvar g = 0; g < NCH; g++) begin : g_a
    localparam logic [AW-1:0] TXA = AW'(11 + 5*g + 3);
    localparam logic [AW-1:0] RXA = AW'(11 + 5*g + 4);

    a_r5_tx_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && done && bus_addr == TXA) |=> tx_load[g]);

    a_r6_wr_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && done && bus_addr == TXA) |=> !dma_wr_req[g]);

    a_r6_rd_req_on_push: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push[g] && done && !bus_wr && ch_cfg[g*21 + 15]) |=> dma_rd_req[g]);

    a_r4_rx_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && done && bus_addr == RXA && !rx_push[g]) |=> !dma_rd_req[g]);
  end
endmodule

bind mspi_regfile mspi_regfile_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .done(done), .rx_push(rx_push), .tx_load(tx_load), .ch_cfg(ch_cfg),
  .ch_enable(ch_enable), .dma_wr_req(dma_wr_req), .dma_rd_req(dma_rd_req)
);

// File: tb/test_mspi_regfile.sv
`timescale 1ns/1ps
module test_mspi_regfile;
  localparam int NCH = 4;
  localparam logic [5:0] A_REV = 0, A_SCFG = 4, A_SSTAT = 5, A_IRQS = 6, A_IRQE = 7,
    A_WAKE = 8, A_TEST = 9, A_MODC = 10;

  logic clk = 0, rst_n = 0;
  logic [5:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic mod_single, mod_slave, mod_systest;
  logic [NCH*21-1:0] ch_cfg;
  logic [NCH-1:0] ch_enable, tx_load, dma_wr_req, dma_rd_req;
  logic [NCH*32-1:0] tx_word;
  logic [NCH-1:0] rx_push = 0, eng_tx_empty = 0, eng_eot = 0;
  logic [NCH*32-1:0] rx_word = 0;

  mspi_regfile i_mspi_regfile (.*);

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [20:0] m_cfg [NCH];
  logic [31:0] m_rx [NCH];
  logic m_rxs [NCH], m_txs [NCH], m_eot [NCH];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] ca(input int ch, input int k);
    return 6'(11 + 5*ch + k);
  endfunction

  function automatic logic [31:0] exp_stat(input int ch);
    return {29'b0, m_eot[ch], m_txs[ch], m_rxs[ch]};
  endfunction

  function automatic logic exp_wreq(input int ch);
    return m_cfg[ch][14] & m_txs[ch];
  endfunction

  function automatic logic exp_rreq(input int ch);
    return m_cfg[ch][15] & m_rxs[ch];
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0; d = bus_rdata;
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_cfg[i] = 0; m_rx[i] = 0; m_rxs[i] = 0; m_txs[i] = 1; m_eot[i] = 1;
    end
  endtask

  task automatic poll_done(input string tag, input int zeros);
    logic [31:0] d;
    for (int k = 0; k < zeros; k++) begin
      rd(A_SSTAT, d); chk(tag, d, 0);
    end
    rd(A_SSTAT, d); chk(tag, d, 1);
  endtask

  task automatic check_chan(input int ch, input string tag);
    logic [31:0] d;
    rd(ca(ch, 1), d);
    chk({tag, " status"}, d, exp_stat(ch));
    chk("R6 wreq", {31'b0, dma_wr_req[ch]}, {31'b0, exp_wreq(ch)});
    chk("R6 rreq", {31'b0, dma_rd_req[ch]}, {31'b0, exp_rreq(ch)});
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, v;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    poll_done("R3 hw reset window", 4);

    rd(A_REV, d);  chk("R1 revision", d, 32'h21);
    rd(A_MODC, d); chk("R1 modctrl default", d, 32'h4);
    chk("R1 mod_slave", {31'b0, mod_slave}, 1);
    rd(A_SCFG, d); chk("R1 sysconfig", d, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(ca(c, 0), d); chk("R1 cfg", d, 0);
      rd(ca(c, 2), d); chk("R1 ctrl", d, 0);
      rd(ca(c, 4), d); chk("R1 rx", d, 0);
      check_chan(c, "R1");
    end

    wr(A_MODC, 32'hFFFF_FFFF); rd(A_MODC, d); chk("R8 modctrl mask", d, 32'hD);
    chk("R8 outs", {29'b0, mod_systest, mod_slave, mod_single}, 32'h7);
    wr(A_MODC, 32'h1); rd(A_MODC, d); chk("R8 master single", d, 32'h1);
    chk("R8 outs master", {29'b0, mod_systest, mod_slave, mod_single}, 32'h1);
    v = $urandom; wr(A_IRQS, v); rd(A_IRQS, d); chk("R10 irq status", d, v);
    v = $urandom; wr(A_IRQE, v); rd(A_IRQE, d); chk("R10 irq enable", d, v);
    v = $urandom; wr(A_TEST, v); rd(A_TEST, d); chk("R10 systest", d, v);
    wr(A_WAKE, 32'hFFFF_FFFF); rd(A_WAKE, d); chk("R10 wakeup", d, 1);
    wr(A_SCFG, 32'h1); rd(A_SCFG, d); chk("R10 autoidle", d, 1);
    rd(A_SSTAT, d); chk("R10 no reset on bit0", d, 1);

    wr(A_REV, 32'hFFFF_FFFF); rd(A_REV, d); chk("R9 revision ro", d, 32'h21);
    wr(A_SSTAT, 0); rd(A_SSTAT, d); chk("R9 sysstatus ro", d, 1);
    wr(ca(0, 1), 0); rd(ca(0, 1), d); chk("R9 chan status ro", d, exp_stat(0));
    wr(ca(0, 4), 32'hDEAD_BEEF); rd(ca(0, 4), d); chk("R9 rx ro", d, 0);
    wr(6'd2, 32'hFFFF_FFFF);
    rd(6'd1, d); chk("R9 unmapped", d, 0);
    rd(6'd2, d); chk("R9 unmapped write", d, 0);
    rd(6'd3, d); chk("R9 unmapped", d, 0);
    rd(6'd31, d); chk("R9 unmapped", d, 0);
    rd(6'd63, d); chk("R9 unmapped", d, 0);

    // R2 R7: each bank at its own stride
    for (int c = 0; c < NCH; c++) begin
      v = $urandom;
      wr(ca(c, 0), v); m_cfg[c] = v[20:0];
      wr(ca(c, 2), 32'(c & 1));
    end
    for (int c = 0; c < NCH; c++) begin
      rd(ca(c, 0), d); chk("R2 R7 cfg readback", d, {11'b0, m_cfg[c]});
      chk("R7 ch_cfg", {11'b0, ch_cfg[c*21 +: 21]}, {11'b0, m_cfg[c]});
      chk("R7 ch_enable", {31'b0, ch_enable[c]}, 32'(c & 1));
    end

    // R5 R6 directed on channel 2
    wr(ca(2, 0), 32'h4000); m_cfg[2] = 21'h4000;
    chk("R6 wreq when empty", {31'b0, dma_wr_req[2]}, 1);
    v = 32'hA5A5_1234; wr(ca(2, 3), v); m_txs[2] = 0; m_eot[2] = 0;
    chk("R5 tx_load pulse", {28'b0, tx_load}, 32'h4);
    chk("R5 tx_word", tx_word[64 +: 32], v);
    @(negedge clk);
    chk("R5 tx_load one cycle", {28'b0, tx_load}, 0);
    check_chan(2, "R5");
    eng_tx_empty[2] = 1; @(negedge clk); eng_tx_empty = 0; m_txs[2] = 1;
    check_chan(2, "R5 empty");
    eng_eot[2] = 1; @(negedge clk); eng_eot = 0; m_eot[2] = 1;
    check_chan(2, "R5 eot");

    // R4 R6 directed on channel 3
    wr(ca(3, 0), 32'h8000); m_cfg[3] = 21'h8000;
    rx_word[96 +: 32] = 32'h0BAD_F00D; rx_push[3] = 1; @(negedge clk); rx_push = 0;
    m_rxs[3] = 1; m_rx[3] = 32'h0BAD_F00D;
    chk("R6 rreq after push", {31'b0, dma_rd_req[3]}, 1);
    rd(ca(3, 4), d); m_rxs[3] = 0; chk("R4 rx word", d, 32'h0BAD_F00D);
    chk("R4 rreq after read", {31'b0, dma_rd_req[3]}, 0);
    check_chan(3, "R4");

    for (int it = 0; it < 120; it++) begin
      int op, ch;
      op = $urandom_range(0, 5); ch = $urandom_range(0, NCH-1);
      v = $urandom;
      case (op)
        0: begin
          if (it % 3 == 0) v[15:14] = 2'b11;
          wr(ca(ch, 0), v); m_cfg[ch] = v[20:0];
          rd(ca(ch, 0), d); chk("R7 cfg random", d, {11'b0, m_cfg[ch]});
        end
        1: begin
          wr(ca(ch, 3), v); m_txs[ch] = 0; m_eot[ch] = 0;
          chk("R5 tx_load random", {28'b0, tx_load}, 32'(1 << ch));
          chk("R5 tx_word random", tx_word[ch*32 +: 32], v);
        end
        2: begin eng_tx_empty[ch] = 1; @(negedge clk); eng_tx_empty = 0; m_txs[ch] = 1; end
        3: begin eng_eot[ch] = 1; @(negedge clk); eng_eot = 0; m_eot[ch] = 1; end
        4: begin
          rx_word[ch*32 +: 32] = v; rx_push[ch] = 1; @(negedge clk); rx_push = 0;
          m_rx[ch] = v; m_rxs[ch] = 1;
        end
        default: begin
          rd(ca(ch, 4), d); chk("R4 rx random", d, m_rx[ch]); m_rxs[ch] = 0;
        end
      endcase
      check_chan(ch, "R4 R5 random");
    end

    // R3 soft reset with a write inside the window
    wr(ca(1, 2), 1); wr(A_SCFG, 32'h1);
    wr(A_SCFG, 32'h3);
    wr(A_MODC, 32'h1);
    poll_done("R3 soft reset window", 3);
    model_reset();
    rd(A_MODC, d); chk("R3 write ignored, default modctrl", d, 32'h4);
    rd(A_SCFG, d); chk("R3 sysconfig cleared, bit1 reads 0", d, 0);
    chk("R3 ch_cfg cleared", {11'b0, ch_cfg[20:0]}, 0);
    chk("R3 ch_cfg all zero", {31'b0, |ch_cfg}, 0);
    chk("R3 ch_enable cleared", {28'b0, ch_enable}, 0);
    rd(A_IRQE, d); chk("R3 irq enable cleared", d, 0);
    for (int c = 0; c < NCH; c++) check_chan(c, "R3");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule